// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

This block holds several identical down-counting timer channels behind a small register bus. Each channel keeps a reload value, a live count and a control word. A shared start register has one run bit per channel. While a channel runs, its count falls by one every four input clocks. When a tick finds the count at zero, the channel copies the reload value back into the count and sets a sticky underflow flag. If that channel's interrupt enable is set, the flag drives its interrupt line.

Software clears the flag by writing the control word back with the flag bit low. Writing the flag bit high cannot set it, so a handler can read the control word, clear the flag and write the word back without any risk of creating a false event. A byte register beside the start register is stored and read back.

Top module: `tmr_unit`

## Requirements
- R1: After reset every register reads 0 and all interrupt lines are low.
- R2: The register map is as follows. Offset 0x0 holds an 8-bit output-control byte that is stored and read back. Offset 0x4 holds the 8-bit start byte, and its bit n runs channel n. Channel n begins at 0x8 + 0xC*n, with the 32-bit reload value at +0x0, the 32-bit count at +0x4 and the 16-bit control word at +0x8. Upper bits of narrow registers read 0, and unmapped offsets read 0 and ignore writes.
- R3: While a channel's start bit is 1, its count falls by one on every fourth clock edge. The first decrement lands on the fourth edge after the edge that wrote the start bit from 0 to 1.
- R4: While a channel's start bit is 0, its count holds and its prescaler returns to zero, so after a restart the first decrement again lands on the fourth edge.
- R5: A tick that finds the count at 0 loads the reload value into the count and sets control bit 8, the underflow flag, on the same edge.
- R6: A control write with bit 8 at 0 clears the flag. A control write with bit 8 at 1 leaves the flag as it was. All other control bits take the written value.
- R7: If an underflow and a flag-clearing control write share an edge, the flag ends at 1.
- R8: Interrupt line n is high exactly when channel n's flag is 1 and its control bit 5 (interrupt enable) is 1.
- R9: Channels are independent. A channel whose start bit is 0 keeps its count while another channel runs.
- R10: A bus write to a count register on the same edge as a tick wins: the count takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe, sampled on the rising edge |
| busAddr | input | 6 | Byte offset of the register |
| busWdata | input | 32 | Write data, low bits used by narrow registers |
| busRdata | output | 32 | Combinational read data for busAddr |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
The hardest cases to reach from the ports are the same-edge collisions: a flag-clearing write that lands exactly on the underflow tick, and a count write that lands exactly on a decrement. Before each of these tests the bench drops the start bit for one edge, which zeroes the prescaler. It then raises the start bit and counts edges from that write, so the colliding bus write can be placed on the fourth edge. The first-tick latency and the reload edge are sampled on both sides of the expected edge.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef struct packed {
    logic tick;
    logic underflow;
  } chStrobe_t;

  localparam int FLAG_BIT = 8;
  localparam int IE_BIT   = 5;
endpackage

// File: rtl/tmr_chan_ctl.sv
`timescale 1ns/1ps
module tmr_chan_ctl
  import tmr_pkg::*;
#(
  parameter int PRE_DIV = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      run,
  input  logic      countIsZero,
  output chStrobe_t strb
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !run) preCnt <= '0;
    else if (preCnt == PRE_LAST) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end

  assign strb.tick      = run && (preCnt == PRE_LAST);
  assign strb.underflow = strb.tick && countIsZero;

  generate
    if (PRE_DIV > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
        strb.tick |=> !strb.tick); // R3
    end
  endgenerate

  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !strb.tick); // R4
endmodule

// File: rtl/tmr_chan_data.sv
`timescale 1ns/1ps
module tmr_chan_data
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int CTL_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  chStrobe_t        strb,
  input  logic             constWr,
  input  logic             countWr,
  input  logic             ctrlWr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] constReg,
  output logic [CNT_W-1:0] countReg,
  output logic [CTL_W-1:0] ctrlReg,
  output logic             countIsZero,
  output logic             irq
);
  localparam logic [CTL_W-1:0] FLAG_MASK = CTL_W'(1) << FLAG_BIT;

  logic [CTL_W-1:0] ctlBits;
  logic             flag;

  always_ff @(posedge clk) begin
    if (!rstN) constReg <= '0;
    else if (constWr) constReg <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) countReg <= '0;
    else if (countWr) countReg <= wdata;
    else if (strb.underflow) countReg <= constReg;
    else if (strb.tick) countReg <= countReg - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctlBits <= '0;
    else if (ctrlWr) ctlBits <= wdata[CTL_W-1:0] & ~FLAG_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flag <= 1'b0;
    else if (strb.underflow) flag <= 1'b1;
    else if (ctrlWr && !wdata[FLAG_BIT]) flag <= 1'b0;
  end

  assign countIsZero = (countReg == '0);
  assign ctrlReg     = ctlBits | (flag ? FLAG_MASK : '0);
  assign irq         = flag && ctlBits[IE_BIT];

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.underflow && !countWr |=> countReg == $past(constReg)); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.underflow |=> ctrlReg[FLAG_BIT]); // R7
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[FLAG_BIT] && !strb.underflow |=> !ctrlReg[FLAG_BIT]); // R6
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick && !countIsZero && !countWr |=> countReg == $past(countReg) - 1'b1); // R3
endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int CNT_W     = 32,
  parameter int CTL_W     = 16,
  parameter int PRE_DIV   = 4,
  parameter int ADDR_W    = 6,
  parameter int CH_BASE   = 8,
  parameter int CH_STRIDE = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic [NUM_CH-1:0] irq
);
  localparam logic [ADDR_W-1:0] OUTCTL_OFF = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] START_OFF  = ADDR_W'(4);

  logic [7:0]       outCtlReg;
  logic [7:0]       startReg;
  logic [CNT_W-1:0] constQ [NUM_CH];
  logic [CNT_W-1:0] countQ [NUM_CH];
  logic [CTL_W-1:0] ctrlQ  [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCtlReg <= '0;
      startReg  <= '0;
    end else if (busWr) begin
      if (busAddr == OUTCTL_OFF) outCtlReg <= busWdata[7:0];
      if (busAddr == START_OFF)  startReg  <= busWdata[7:0];
    end
  end

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE + CH_STRIDE * ch);
      chStrobe_t strb;
      logic      zero;

      tmr_chan_ctl #(.PRE_DIV(PRE_DIV)) u_ctl (
        .clk        (clk),
        .rstN       (rstN),
        .run        (startReg[ch]),
        .countIsZero(zero),
        .strb       (strb)
      );

      tmr_chan_data #(.CNT_W(CNT_W), .CTL_W(CTL_W)) u_data (
        .clk        (clk),
        .rstN       (rstN),
        .strb       (strb),
        .constWr    (busWr && busAddr == BASE),
        .countWr    (busWr && busAddr == BASE + ADDR_W'(4)),
        .ctrlWr     (busWr && busAddr == BASE + ADDR_W'(8)),
        .wdata      (busWdata),
        .constReg   (constQ[ch]),
        .countReg   (countQ[ch]),
        .ctrlReg    (ctrlQ[ch]),
        .countIsZero(zero),
        .irq        (irq[ch])
      );
    end
  endgenerate

  always_comb begin
    busRdata = '0;
    if (busAddr == OUTCTL_OFF) busRdata = CNT_W'(outCtlReg);
    if (busAddr == START_OFF)  busRdata = CNT_W'(startReg);
    for (int i = 0; i < NUM_CH; i++) begin
      if (busAddr == ADDR_W'(CH_BASE + CH_STRIDE * i))     busRdata = constQ[i];
      if (busAddr == ADDR_W'(CH_BASE + CH_STRIDE * i + 4)) busRdata = countQ[i];
      if (busAddr == ADDR_W'(CH_BASE + CH_STRIDE * i + 8)) busRdata = CNT_W'(ctrlQ[i]);
    end
  end
endmodule

// File: tb/tmr_unit_tb.sv
`timescale 1ns/1ps
module tmr_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_unit u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  typedef struct packed {
    logic [5:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{6'h00, 32'hA5A5A5A5, 32'h000000A5},
    '{6'h08, 32'h12345678, 32'h12345678},
    '{6'h0C, 32'h000000F0, 32'h000000F0},
    '{6'h10, 32'hFFFF0020, 32'h00000020},
    '{6'h14, 32'hCAFE0001, 32'hCAFE0001},
    '{6'h18, 32'h00000040, 32'h00000040},
    '{6'h1C, 32'h000000AB, 32'h000000AB},
    '{6'h20, 32'h0BADF00D, 32'h0BADF00D},
    '{6'h28, 32'h00001E40, 32'h00001E40},
    '{6'h2C, 32'hFFFFFFFF, 32'h00000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    busAddr = a;
    #0.1;
    d = busRdata;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, held;
    waitN(3);
    rstN = 1'b1;
    waitN(1);

    // R1 reset state
    rd(6'h00, v); chk("R1 outctl", v, 0);
    rd(6'h04, v); chk("R1 start", v, 0);
    rd(6'h0C, v); chk("R1 count0", v, 0);
    rd(6'h28, v); chk("R1 ctrl2", v, 0);
    chk("R1 irq", {29'd0, irq}, 0);

    // R2 register map walk
    for (int i = 0; i < NV; i++) begin
      wr(TBL[i].a, TBL[i].d);
      rd(TBL[i].a, v);
      chk($sformatf("R2 addr %h", TBL[i].a), v, TBL[i].e);
    end
    chk("R8 no flag no irq", {29'd0, irq}, 0);

    // R3 / R5 / R8 on channel 0
    wr(6'h08, 5); wr(6'h0C, 3); wr(6'h10, 32'h20);
    wr(6'h04, 1);
    waitN(3); rd(6'h0C, v); chk("R3 before first tick", v, 3);
    waitN(1); rd(6'h0C, v); chk("R3 first tick", v, 2);
    waitN(7); rd(6'h0C, v); chk("R3 period", v, 1);
    waitN(4); rd(6'h0C, v); chk("R5 at zero", v, 0);
    rd(6'h10, v); chk("R5 flag not yet", v, 32'h20);
    chk("R8 irq low", {29'd0, irq}, 0);
    waitN(1); rd(6'h0C, v); chk("R5 reload", v, 5);
    rd(6'h10, v); chk("R5 flag set", v, 32'h120);
    chk("R8 irq high", {29'd0, irq}, 3'b001);
    rd(6'h18, v); chk("R9 ch1 idle", v, 32'h40);

    // R6 flag write rules
    wr(6'h04, 0);
    wr(6'h10, 32'h120); rd(6'h10, v); chk("R6 write one keeps", v, 32'h120);
    wr(6'h10, 32'h020); rd(6'h10, v); chk("R6 clear", v, 32'h020);
    chk("R8 irq after clear", {29'd0, irq}, 0);
    wr(6'h10, 32'h120); rd(6'h10, v); chk("R6 cannot set", v, 32'h020);

    // R4 stop and restart
    rd(6'h0C, held);
    waitN(10); rd(6'h0C, v); chk("R4 hold", v, held);
    wr(6'h0C, 9); wr(6'h04, 1);
    waitN(3); rd(6'h0C, v); chk("R4 restart latency", v, 9);
    waitN(1); rd(6'h0C, v); chk("R4 restart tick", v, 8);

    // R7 underflow on same edge as clear write
    wr(6'h04, 0); wr(6'h0C, 0); wr(6'h08, 7);
    wr(6'h04, 1);
    waitN(3);
    wr(6'h10, 32'h020);
    rd(6'h10, v); chk("R7 set wins", v, 32'h120);
    rd(6'h0C, v); chk("R5 reload from zero", v, 7);

    // R10 count write on tick edge
    wr(6'h04, 0); wr(6'h0C, 32'h50);
    wr(6'h04, 1);
    waitN(3);
    wr(6'h0C, 32'h100);
    rd(6'h0C, v); chk("R10 write wins", v, 32'h100);
    waitN(3); rd(6'h0C, v); chk("R10 no early tick", v, 32'h100);
    waitN(1); rd(6'h0C, v); chk("R10 next tick", v, 32'hFF);

    // R9 channel independence
    wr(6'h04, 0);
    wr(6'h18, 32'h40); wr(6'h24, 32'h80);
    rd(6'h0C, held);
    wr(6'h04, 2);
    waitN(4);
    rd(6'h18, v); chk("R9 ch1 runs", v, 32'h3F);
    rd(6'h24, v); chk("R9 ch2 holds", v, 32'h80);
    rd(6'h0C, v); chk("R9 ch0 holds", v, held);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule